// File: doc/BRIEF.md
# Two-Channel Phase-Aligned Clock Divider

This block derives two slower clocks from one fast input clock. Each channel has its own integer divide ratio, phase offset and enable. After a realignment event, each channel waits a programmable number of input clock periods before its first rising edge. Because the wait is counted in input periods, the two outputs keep a fixed, programmable phase relationship.

A realignment is requested by pulling an active-low sync input low. The request is captured asynchronously, so it works even while the input clock is stopped. While sync is low, every divided channel parks its output low. Release of sync passes through a two-stage synchronizer, and the divided channels start again a fixed number of input cycles later. Reset release performs the same realignment, so both channels start aligned. A channel set to divide by one passes the input clock straight through and takes no part in realignment. A disabled channel drives low and freezes its counters.

Top module: `dual_phase_divider`

## Requirements
- R1: A ratio field value F selects division by N = F + 1 (1 to 32). In steady running, a divided channel (F ≥ 1) has a period of N input cycles and is high for floor(N/2) of them.
- R2: A ratio field of 0 selects bypass: while enabled, the channel output equals the input clock.
- R3: Let K be the phase word (0 to 15) taken modulo N. After a realignment, the first rising edge of a divided channel is registered K input cycles after its earliest possible edge. Phase words that differ by a multiple of N therefore give the same alignment.
- R4: While sync is low, every enabled divided channel drives low from the first input clock edge after sync falls.
- R5: Release of sync is synchronized by two flops. Divided channels resume 4 input cycles after the synchronized release. With phase 0, the output rises at the 6th input clock rising edge after sync rises, counting the first edge after the release as edge 1. It is low before that edge.
- R6: A low pulse on sync applied while the input clock is stopped is still captured. When the clock restarts, the outputs follow the timing of R4 and R5, counted from the first edge after the restart.
- R7: A bypassed channel keeps following the input clock while sync is low.
- R8: Reset drives both divided outputs low. Release of reset acts as a sync release with the same timing as R5.
- R9: A disabled channel (enable = 0) drives its output low in both divided and bypass modes, regardless of sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release acts as a realignment |
| sync_ni | input | 1 | Asynchronous active-low realignment request |
| a_en_i | input | 1 | Channel A enable |
| a_ratio_i | input | 5 | Channel A ratio field: divide by value + 1 |
| a_phase_i | input | 4 | Channel A phase offset word, in input cycles |
| b_en_i | input | 1 | Channel B enable |
| b_ratio_i | input | 5 | Channel B ratio field: divide by value + 1 |
| b_phase_i | input | 4 | Channel B phase offset word, in input cycles |
| a_clk_o | output | 1 | Channel A output clock |
| b_clk_o | output | 1 | Channel B output clock |

## Verification
The bench builds the block with its default parameters: a 5-bit ratio field, a 4-bit phase word and a resume latency of 4. These values are small enough to sweep all 32 ratio fields against all 16 phase words. The two channels get mirrored settings, so every pairing of odd and even ratio, bypass, and phase words above, equal to and below the ratio is exercised on both outputs. The expected waveform is computed per edge from the ratio, the wrapped phase and the fixed release latency. The clock can also be halted in the bench, which exercises a sync pulse that arrives with no clock running.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  localparam int unsigned RATIO_W_DEF    = 5;
  localparam int unsigned PHASE_W_DEF    = 4;
  localparam int unsigned RESUME_LAT_DEF = 4;

  // Number of input cycles a divided output spends high per period.
  function automatic int unsigned high_span(int unsigned n);
    return n / 2;
  endfunction

  // Phase word folded into one output period.
  function automatic int unsigned wrap_phase(int unsigned ph, int unsigned n);
    return (n == 0) ? 0 : ph % n;
  endfunction

endpackage

// File: rtl/dpd_sync_ctl.sv
module dpd_sync_ctl
  import dpd_pkg::*;
#(
  parameter int unsigned LAT = RESUME_LAT_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  output logic sync_q_o,
  output logic run_o
);

  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic clr_n;
  logic meta_q, stab_q;
  logic [CW-1:0] rel_q;

  // Either reset or a sync request clears the synchronizer at once.
  assign clr_n = rst_ni & sync_ni;

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      stab_q <= meta_q;
    end
  end

  // Counts input cycles since the synchronized release, saturating.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
    end else if (!stab_q) begin
      rel_q <= '0;
    end else if (rel_q != LAST) begin
      rel_q <= rel_q + 1'b1;
    end
  end

  assign sync_q_o = stab_q;
  assign run_o    = stab_q & (rel_q == LAST);

endmodule

// File: rtl/dpd_channel.sv
module dpd_channel
  import dpd_pkg::*;
#(
  parameter int unsigned RW = RATIO_W_DEF,
  parameter int unsigned PW = PHASE_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          en_i,
  input  logic [RW-1:0] ratio_i,
  input  logic [PW-1:0] phase_i,
  output logic          div_q_o,
  output logic          clk_o
);

  localparam int unsigned NW = RW + 1;

  logic [NW-1:0] n_div;
  logic [NW-1:0] half;
  logic [PW-1:0] dly_load;
  logic          bypass;
  logic          step;

  logic [RW-1:0] pos_q;
  logic [PW-1:0] dly_q;
  logic          out_q;

  assign n_div    = NW'(ratio_i) + NW'(1);
  assign half     = NW'(high_span(32'(n_div)));
  assign dly_load = PW'(wrap_phase(32'(phase_i), 32'(n_div)));
  assign bypass   = (ratio_i == '0);
  assign step     = en_i & ~bypass & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      dly_q <= '0;
      out_q <= 1'b0;
    end else if (!step) begin
      // Parked: low output, position at period start, delay preloaded.
      pos_q <= '0;
      dly_q <= dly_load;
      out_q <= 1'b0;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else begin
      out_q <= (NW'(pos_q) < half);
      pos_q <= (pos_q >= ratio_i) ? '0 : pos_q + 1'b1;
    end
  end

  assign div_q_o = out_q;
  assign clk_o   = en_i & (bypass ? clk_i : out_q);

endmodule

// File: rtl/dual_phase_divider.sv
module dual_phase_divider
  import dpd_pkg::*;
#(
  parameter int unsigned RW  = RATIO_W_DEF,
  parameter int unsigned PW  = PHASE_W_DEF,
  parameter int unsigned LAT = RESUME_LAT_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_ni,
  input  logic          a_en_i,
  input  logic [RW-1:0] a_ratio_i,
  input  logic [PW-1:0] a_phase_i,
  input  logic          b_en_i,
  input  logic [RW-1:0] b_ratio_i,
  input  logic [PW-1:0] b_phase_i,
  output logic          a_clk_o,
  output logic          b_clk_o
);

  localparam int unsigned NCH = 2;

  logic               sync_q;
  logic               run;
  logic [NCH-1:0]     en_v;
  logic [NCH-1:0]     div_q;
  logic [NCH-1:0]     clk_v;
  logic [RW-1:0]      ratio_v [NCH];
  logic [PW-1:0]      phase_v [NCH];

  assign en_v       = {b_en_i, a_en_i};
  assign ratio_v[0] = a_ratio_i;
  assign ratio_v[1] = b_ratio_i;
  assign phase_v[0] = a_phase_i;
  assign phase_v[1] = b_phase_i;

  dpd_sync_ctl #(.LAT(LAT)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_ni  (sync_ni),
    .sync_q_o (sync_q),
    .run_o    (run)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dpd_channel #(.RW(RW), .PW(PW)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .en_i    (en_v[c]),
      .ratio_i (ratio_v[c]),
      .phase_i (phase_v[c]),
      .div_q_o (div_q[c]),
      .clk_o   (clk_v[c])
    );
  end

  assign a_clk_o = clk_v[0];
  assign b_clk_o = clk_v[1];

endmodule

// File: rtl/dpd_checker.sv
module dpd_checker #(
  parameter int unsigned RW  = 5,
  parameter int unsigned PW  = 4,
  parameter int unsigned LAT = 4,
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sync_q,
  input logic           run,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] div_q,
  input logic [RW-1:0]  ratio [NCH],
  input logic [PW-1:0]  phase [NCH]
);

  localparam int unsigned CW  = ((RW > PW) ? RW : PW) + 2;
  localparam int unsigned HW  = $clog2(LAT) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [HW-1:0]  hi_cnt;
  logic [CW-1:0]  run_cnt;
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] seen;
  logic [CW-1:0]  gap [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
    end else if (!sync_q) begin
      hi_cnt <= '0;
    end else if (hi_cnt < HW'(LAT - 1)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
    end else if (!run) begin
      run_cnt <= '0;
    end else if (run_cnt != CMAX) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= div_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic active;
    logic rose;
    assign active = run & en[c] & (ratio[c] != '0);
    assign rose   = div_q[c] & ~prev_q[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen[c] <= 1'b0;
        gap[c]  <= '0;
      end else if (!active) begin
        seen[c] <= 1'b0;
        gap[c]  <= '0;
      end else if (rose) begin
        seen[c] <= 1'b1;
        gap[c]  <= CW'(1);
      end else if (gap[c] != CMAX) begin
        gap[c]  <= gap[c] + 1'b1;
      end
    end

    // R1: rising edges of a running divided channel are N cycles apart
    a_r1_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && rose && seen[c]) |-> (gap[c] == CW'(ratio[c]) + CW'(1)));

    // R3: first edge lands phase-mod-N cycles after resume
    a_r3_first_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && rose && !seen[c]) |->
        (int'(run_cnt) == (int'(phase[c]) % (int'(ratio[c]) + 1)) + 1));

    // R9: a disabled channel keeps its divider output low
    a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en[c] |=> !div_q[c]);
  end

  // R4: sync low parks every divider output low on the next edge
  a_r4_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_q |=> (div_q == '0));

  // R5: resume only after the fixed latency from the synchronized release
  a_r5_resume_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (hi_cnt >= HW'(LAT - 1)));

  a_r5_resume_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && hi_cnt >= HW'(LAT - 1)) |-> run);

endmodule

bind dual_phase_divider dpd_checker #(.RW(RW), .PW(PW), .LAT(LAT), .NCH(2)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sync_q (sync_q),
  .run    (run),
  .en     (en_v),
  .div_q  (div_q),
  .ratio  (ratio_v),
  .phase  (phase_v)
);

// File: tb/sim_dual_phase_divider.sv
module sim_dual_phase_divider;

  localparam int LAT = 4;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n, sync_n;
  logic a_en, b_en;
  logic [4:0] a_r, b_r;
  logic [3:0] a_p, b_p;
  logic a_o, b_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always begin
    #5;
    if (clk_run) clk = ~clk;
  end

  dual_phase_divider u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_ni(sync_n),
    .a_en_i(a_en), .a_ratio_i(a_r), .a_phase_i(a_p),
    .b_en_i(b_en), .b_ratio_i(b_r), .b_phase_i(b_p),
    .a_clk_o(a_o), .b_clk_o(b_o)
  );

  // Expected divided output after edge j counted from a release.
  function automatic logic model(int j, int f, int ph, logic en);
    int n, k, m;
    n = f + 1;
    k = ph % n;
    m = j - (2 + LAT) - k;
    if (!en || m < 0) return 1'b0;
    return ((m % n) < (n / 2));
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_chan(string ctx, int j, logic act, int f, int ph, logic en, bit hi);
    int n, k;
    string tag;
    if (!en) begin
      chk({ctx, " R9 disabled"}, act, 1'b0);
    end else if (f == 0) begin
      chk({ctx, " R2 bypass"}, act, hi);
    end else begin
      n = f + 1;
      k = ph % n;
      if (j < 2 + LAT + k)       tag = " R5 resume latency";
      else if (j == 2 + LAT + k) tag = " R3 first edge";
      else                       tag = " R1 period/duty";
      chk({ctx, tag}, act, model(j, f, ph, en));
    end
  endtask

  task automatic follow(int nedges, string ctx);
    for (int j = 1; j <= nedges; j++) begin
      @(posedge clk); #2;
      chk_chan(ctx, j, a_o, int'(a_r), int'(a_p), a_en, 1'b1);
      chk_chan(ctx, j, b_o, int'(b_r), int'(b_p), b_en, 1'b1);
      @(negedge clk); #2;
      chk_chan(ctx, j, a_o, int'(a_r), int'(a_p), a_en, 1'b0);
      chk_chan(ctx, j, b_o, int'(b_r), int'(b_p), b_en, 1'b0);
    end
  endtask

  task automatic chk_hold(logic act, logic [4:0] f, logic en, bit hi);
    if (f == 5'd0) chk("R7 bypass during sync", act, en & hi);
    else           chk("R4 hold low", act, 1'b0);
  endtask

  task automatic hold(int nedges);
    for (int j = 0; j < nedges; j++) begin
      @(posedge clk); #2;
      chk_hold(a_o, a_r, a_en, 1'b1);
      chk_hold(b_o, b_r, b_en, 1'b1);
      @(negedge clk); #2;
      chk_hold(a_o, a_r, a_en, 1'b0);
      chk_hold(b_o, b_r, b_en, 1'b0);
    end
  endtask

  task automatic sync_run(int fa, int pa, logic ea, int fb, int pb, logic eb,
                          int nedges, string ctx);
    @(negedge clk); #1;
    sync_n = 1'b0;
    a_r = 5'(fa); a_p = 4'(pa); a_en = ea;
    b_r = 5'(fb); b_p = 4'(pb); b_en = eb;
    hold(2);
    @(negedge clk); #1;
    sync_n = 1'b1;
    follow(nedges, ctx);
  endtask

  initial begin
    rst_n = 1'b0; sync_n = 1'b1;
    a_r = 5'd3; a_p = 4'd1; a_en = 1'b1;
    b_r = 5'd2; b_p = 4'd0; b_en = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #2;
      chk("R8 reset state A", a_o, 1'b0);
      chk("R8 reset state B", b_o, 1'b0);
    end
    @(negedge clk); #1;
    rst_n = 1'b1;
    follow(30, "R8 reset release");

    // Mirrored exhaustive sweep of ratio field and phase word.
    for (int f = 0; f < 32; f++) begin
      for (int p = 0; p < 16; p++) begin
        sync_run(f, p, 1'b1, 31 - f, 15 - p, 1'b1, 2 + LAT + 15 + 66, "sweep");
      end
    end

    // Disabled channels, divided and bypass.
    sync_run(4, 2, 1'b0, 0, 0, 1'b0, 30, "R9 both off");
    sync_run(0, 0, 1'b0, 6, 5, 1'b0, 30, "R9 both off alt");
    sync_run(4, 2, 1'b0, 0, 0, 1'b1, 30, "R9 mixed");

    // Sync pulse while the clock is halted.
    sync_run(31, 0, 1'b1, 7, 3, 1'b1, 12, "R6 setup");
    @(negedge clk);
    clk_run = 1'b0;
    #3 sync_n = 1'b0;
    #5 sync_n = 1'b1;
    #10 clk_run = 1'b1;
    follow(80, "R6 async capture");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule